// File: doc/BRIEF.md
# Panel Polarity Inversion Controller

This block drives the one-bit polarity-inversion level that a liquid-crystal panel uses to keep its cells free of a standing DC bias. It runs on the pixel clock. A line strobe marks the horizontal sync edge and carries the number of the line that is starting. A field strobe marks the vertical sync. From these strobes it decides when the inversion level flips.

A two-bit field counter starts counting at the first field strobe after reset. At every field strobe the output is loaded with a base level taken from that counter. One counter bit gives a pattern that repeats every two fields, which is half the vertical rate. The other bit gives a pattern that repeats every four fields, which is a quarter of the vertical rate. A rate select input chooses between them.

Inside a field the level flips in the back porch of each line of a fixed window. The flip happens a fixed number of pixel clocks after the line strobe. One extra flip happens at an early line in every other field. A mode input chooses between two modes:
- Pixel inversion, for normal video: the per-line flips are made.
- Column inversion, for abnormal video such as pause or search: the per-line flips are suppressed, and only the field pattern and the early-line flip remain.

The rate setting applies in both modes.

Top module: `pol_inv_ctrl`

## Requirements
- R1: After reset `polOut` is 0. It stays 0, and makes no per-line or extra flips, until the first `fieldStb` is seen.
- R2: The first `fieldStb` after reset sets the field count to 0. Each later `fieldStb` adds 1 to it, modulo 4.
- R3: On the clock edge that samples `fieldStb`, `polOut` takes the base level. When `quarterRate`=0 the base level is bit 0 of the new field count, so the pattern repeats every 2 fields. When `quarterRate`=1 it is bit 1 of the new field count, so the pattern repeats every 4 fields.
- R4: When `colMode`=0, a `lineStb` whose `lineNum` lies in FIRST_LINE..LAST_LINE (inclusive) inverts `polOut`. The inversion happens on the clock edge exactly BP_DLY cycles after the edge that sampled `lineStb`, and `polOut` holds its value before that edge.
- R5: A `lineStb` with `lineNum` outside FIRST_LINE..LAST_LINE causes no per-line inversion.
- R6: A `lineStb` with `lineNum`=EXTRA_LINE in a field whose count is even causes one extra inversion, with the same BP_DLY timing, in both modes.
- R7: When `colMode`=1, the per-line inversions of R4 are suppressed.
- R8: `colMode` and `lineNum` are sampled at the `lineStb` edge. A change of `colMode` during the delay does not alter the pending decision.
- R9: A `fieldStb` that arrives while an inversion is pending cancels that inversion. `polOut` then shows only the base level of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineStb | input | 1 | One-cycle pulse at the horizontal sync edge |
| lineNum | input | LINE_W | Number of the starting line, valid with `lineStb` |
| fieldStb | input | 1 | One-cycle pulse at the vertical sync |
| colMode | input | 1 | 1 selects column inversion, 0 selects pixel inversion |
| quarterRate | input | 1 | 1 selects a quarter-rate pattern, 0 selects a half-rate pattern |
| polOut | output | 1 | Inversion control level to the panel |

## Verification
The bench builds the block with FIRST_LINE=6, LAST_LINE=12, EXTRA_LINE=2 and BP_DLY=4, and feeds it fields of 16 lines. With this small window a sweep can cover every line of eight fields in all four combinations of mode and rate. That reaches every field-count phase, both window edges, the extra-line flip and the repeat of the pattern every two and every four fields. Each flip is checked one cycle before and at its exact edge. Separate cases cover the unsynchronised start, a mode change during the delay, and a field strobe that cancels a pending flip.

// File: rtl/pol_inv_pkg.sv
package pol_inv_pkg;
  // Strobes from the sequencer to the level register
  typedef struct packed {
    logic setBase;   // load base level (field start)
    logic baseLvl;   // base level to load
    logic toggle;    // invert the level
  } polStrobe_t;
endpackage

// File: rtl/pol_inv_seq.sv
module pol_inv_seq
  import pol_inv_pkg::*;
#(
  parameter int LINE_W     = 10,
  parameter int FIRST_LINE = 22,
  parameter int LAST_LINE  = 261,
  parameter int EXTRA_LINE = 4,
  parameter int BP_DLY     = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStb,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              fieldStb,
  input  logic              colMode,
  input  logic              quarterRate,
  output polStrobe_t        strb
);
  localparam int DLY_W = $clog2(BP_DLY + 1);
  localparam logic [DLY_W-1:0]  DLY_LOAD = DLY_W'(BP_DLY - 1);
  localparam logic [LINE_W-1:0] FIRST_L  = LINE_W'(FIRST_LINE);
  localparam logic [LINE_W-1:0] LAST_L   = LINE_W'(LAST_LINE);
  localparam logic [LINE_W-1:0] EXTRA_L  = LINE_W'(EXTRA_LINE);

  logic             synced;
  logic [1:0]       fieldCnt;
  logic [1:0]       nextCnt;
  logic             pend;
  logic [DLY_W-1:0] dlyCnt;
  logic             inWin;
  logic             qual;

  assign inWin   = (lineNum >= FIRST_L) && (lineNum <= LAST_L);
  assign qual    = synced && ((!colMode && inWin) ||
                              ((lineNum == EXTRA_L) && !fieldCnt[0]));
  assign nextCnt = synced ? fieldCnt + 2'd1 : 2'd0;

  always_comb begin
    strb.setBase = fieldStb;
    strb.baseLvl = quarterRate ? nextCnt[1] : nextCnt[0];
    strb.toggle  = pend && (dlyCnt == '0) && !fieldStb;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      synced   <= 1'b0;
      fieldCnt <= 2'd0;
      pend     <= 1'b0;
      dlyCnt   <= '0;
    end else if (fieldStb) begin
      synced   <= 1'b1;
      fieldCnt <= nextCnt;
      pend     <= 1'b0;
    end else if (lineStb) begin
      pend   <= qual;
      dlyCnt <= DLY_LOAD;
    end else if (pend) begin
      if (dlyCnt == '0) pend <= 1'b0;
      else              dlyCnt <= dlyCnt - DLY_W'(1);
    end
  end

  // R1: no flip before the first field strobe
  a_r1_no_toggle_unsynced: assert property (@(posedge clk) disable iff (!rstN)
    !synced |-> !strb.toggle);
  // R2: field count steps by one once synchronised
  a_r2_field_step: assert property (@(posedge clk) disable iff (!rstN)
    (synced && fieldStb) |=> fieldCnt == $past(fieldCnt) + 2'd1);
  // R4: at most one flip per line strobe
  a_r4_single_flip: assert property (@(posedge clk) disable iff (!rstN)
    (strb.toggle && !lineStb) |=> !strb.toggle);
endmodule

// File: rtl/pol_inv_level.sv
module pol_inv_level
  import pol_inv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  polStrobe_t strb,
  output logic       polOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             polOut <= 1'b0;
    else if (strb.setBase) polOut <= strb.baseLvl;
    else if (strb.toggle)  polOut <= ~polOut;
  end

  // R4: level holds without a strobe
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.setBase && !strb.toggle) |=> $stable(polOut));
  // R4: a flip strobe inverts the level
  a_r4_flip: assert property (@(posedge clk) disable iff (!rstN)
    (strb.toggle && !strb.setBase) |=> polOut != $past(polOut));
endmodule

// File: rtl/pol_inv_ctrl.sv
module pol_inv_ctrl
  import pol_inv_pkg::*;
#(
  parameter int LINE_W     = 10,
  parameter int FIRST_LINE = 22,
  parameter int LAST_LINE  = 261,
  parameter int EXTRA_LINE = 4,
  parameter int BP_DLY     = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStb,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              fieldStb,
  input  logic              colMode,
  input  logic              quarterRate,
  output logic              polOut
);
  polStrobe_t strb;

  pol_inv_seq #(
    .LINE_W(LINE_W), .FIRST_LINE(FIRST_LINE), .LAST_LINE(LAST_LINE),
    .EXTRA_LINE(EXTRA_LINE), .BP_DLY(BP_DLY)
  ) i_seq (
    .clk(clk), .rstN(rstN), .lineStb(lineStb), .lineNum(lineNum),
    .fieldStb(fieldStb), .colMode(colMode), .quarterRate(quarterRate),
    .strb(strb)
  );

  pol_inv_level i_level (
    .clk(clk), .rstN(rstN), .strb(strb), .polOut(polOut)
  );
endmodule

// File: tb/test_pol_inv_ctrl.sv
module test_pol_inv_ctrl;
  localparam int LW = 10, FL = 6, LL = 12, XL = 2, DL = 4, NLINES = 16;

  logic clk = 1'b0, rstN = 1'b0, lineStb = 1'b0, fieldStb = 1'b0;
  logic colMode = 1'b0, quarterRate = 1'b0;
  logic [LW-1:0] lineNum = '0;
  logic polOut;

  int errors = 0, checks = 0;
  bit synced = 0;
  int cnt = 0;
  bit pol = 0;

  always #5 clk = ~clk;

  pol_inv_ctrl #(.LINE_W(LW), .FIRST_LINE(FL), .LAST_LINE(LL),
                 .EXTRA_LINE(XL), .BP_DLY(DL)) i_pol_inv_ctrl (
    .clk(clk), .rstN(rstN), .lineStb(lineStb), .lineNum(lineNum),
    .fieldStb(fieldStb), .colMode(colMode), .quarterRate(quarterRate),
    .polOut(polOut));

  task automatic check(input string req, input bit exp);
    checks++;
    if (polOut !== exp) begin
      errors++;
      $display("FAIL %s: polOut=%0b expected=%0b at %0t", req, polOut, exp, $time);
    end
  endtask

  task automatic doField(input string req);
    fieldStb = 1'b1;
    @(posedge clk); #1;
    fieldStb = 1'b0;
    if (!synced) begin synced = 1; cnt = 0; end
    else cnt = (cnt + 1) % 4;
    pol = quarterRate ? cnt[1] : cnt[0];
    #1 check(req, pol);
    @(posedge clk); #1;
  endtask

  task automatic doLine(input int ln);
    bit tgl;
    bit oldPol;
    lineNum = LW'(ln);
    lineStb = 1'b1;
    @(posedge clk); #1;
    lineStb = 1'b0;
    tgl = synced && ((!colMode && ln >= FL && ln <= LL) ||
                     (ln == XL && cnt[0] == 1'b0));
    oldPol = pol;
    if (tgl) pol = ~pol;
    repeat (DL - 1) @(posedge clk);
    #2 check(colMode ? "R7 hold before edge" : "R4 hold before edge", oldPol);
    @(posedge clk); #2;
    if (!synced) check("R1 no flip unsynced", pol);
    else if (ln == XL) check("R6 extra flip", pol);
    else if (ln < FL || ln > LL) check("R5 outside window", pol);
    else if (colMode) check("R7 column suppress", pol);
    else check("R4 window flip", pol);
    repeat (3) @(posedge clk); #1;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    check("R1 reset", 1'b0);
    rstN = 1'b1;
    @(posedge clk); #1;
    // R1: lines before sync
    for (int l = 0; l < NLINES; l++) doLine(l);
    // R2/R3 and R4..R7: sweep all modes and rates over eight fields
    for (int m = 0; m < 4; m++) begin
      colMode = m[0];
      quarterRate = m[1];
      for (int f = 0; f < 8; f++) begin
        doField(quarterRate ? "R3 quarter base" : "R2 R3 half base");
        for (int l = 0; l < NLINES; l++) doLine(l);
      end
    end
    // R8: mode changed during delay does not alter the decision
    quarterRate = 1'b0; colMode = 1'b0;
    doField("R3 base");
    lineNum = LW'(FL); lineStb = 1'b1;
    @(posedge clk); #1;
    lineStb = 1'b0; colMode = 1'b1;
    pol = ~pol;
    repeat (DL) @(posedge clk);
    #2 check("R8 sampled mode", pol);
    colMode = 1'b0;
    repeat (3) @(posedge clk); #1;
    // R9: field strobe cancels a pending flip
    lineNum = LW'(FL + 1); lineStb = 1'b1;
    @(posedge clk); #1;
    lineStb = 1'b0;
    doField("R9 field base");
    repeat (DL + 2) @(posedge clk);
    #2 check("R9 pending cancelled", pol);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule